// File: doc/BRIEF.md
# Fractional Multiply-Accumulate-Round Unit

This block performs one fused operation on fixed-point fractional data. Two signed 24-bit operands are multiplied. The product is aligned as a fraction and then added to, or subtracted from, a 56-bit accumulator. The accumulator is made of an 8-bit extension, a 24-bit middle word and a 24-bit low word. The sum is then rounded with round-half-to-even, at a bit position set by a two-bit scaling mode. The low word of the result is forced to zero, so the rounded value sits in the extension and middle words.

Alongside the new accumulator, the block returns six condition flags: limit, extension-in-use, unnormalized, negative, zero and overflow. The limit flag is sticky. The caller feeds the current limit bit back in, and the block ORs overflow into it, so the bit stays set until something outside the block clears it.

A single-cycle start strobe launches an operation. The result and a one-cycle done pulse appear two clock edges later. A new operation may start on every cycle.

Top module: `fmac_round_unit`

## Requirements
- R1: While reset is high, done, the accumulator output and all six flags read zero.
- R2: If start is high at clock edge t, done is high for exactly the cycle after edge t+1, and the result belongs to that operation. Starts on consecutive cycles each produce their own result on consecutive cycles.
- R3: The product is fractional: the 48-bit signed product is doubled and sign-extended to 56 bits. It is added to the accumulator when negate is 0 and subtracted when it is 1. For example, operands 0x123456 and 0x123456 with accumulator 0x00_100000_000000 in scaling mode 00 give 0x00_1296CE_000000.
- R4: The rounding constant 2^p is added to the full-precision sum. p is 23 for scaling mode 00, 24 for mode 01 (scale down), 22 for mode 10 (scale up), and 23 for mode 11.
- R5: On a tie, where bits p..0 of the sum equal exactly 2^p, bit p+1 of the rounded result is cleared (round half to even).
- R6: After rounding, bits 23..0 of the result are zero. In mode 01, bit 24 is also zero.
- R7: The negative flag equals bit 55 of the result. The zero flag is set exactly when all 56 result bits are zero.
- R8: The overflow flag is set when the exact rounded value lies outside the signed 56-bit range. The result is then the low 56 bits of that value.
- R9: The limit flag equals the limit input, captured with start, ORed with overflow.
- R10: The extension flag is clear exactly when result bits 55..k are all equal, with k = 47 in modes 00 and 11, 48 in mode 01 and 46 in mode 10.
- R11: The unnormalized flag is set exactly when result bits k and k-1 are equal, with k as in R10.
- R12: When no operation completes in a cycle, the accumulator output and the flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one operation with the inputs of this cycle |
| op_x | input | 24 | First signed fractional operand |
| op_y | input | 24 | Second signed fractional operand |
| negate | input | 1 | 1 subtracts the product, 0 adds it |
| acc_in | input | 56 | Current accumulator value |
| scale_mode | input | 2 | Scaling mode selecting rounding position and flag windows |
| limit_in | input | 1 | Current sticky limit bit |
| acc_out | output | 56 | Rounded accumulator result |
| done | output | 1 | One-cycle pulse when acc_out and the flags are updated |
| flg_limit | output | 1 | Sticky limit flag |
| flg_ext | output | 1 | Extension portion in use |
| flg_unnorm | output | 1 | Result unnormalized |
| flg_neg | output | 1 | Result negative |
| flg_zero | output | 1 | Result zero |
| flg_ovf | output | 1 | Arithmetic overflow |

## Verification
In the same cycle, the output stage can retire one operation while the first stage captures the next. The bench provokes this with long runs of back-to-back starts that use mixed scaling modes, and the model checks that every result comes from its own operands and mode. Within a single operation, the tie correction can coincide with a rounding carry that ripples into the extension or past bit 55. Directed cases with exact-half low words, and one case where rounding alone overflows, judge the result, overflow and limit together against values worked out by hand.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  typedef struct packed {
    logic lim;
    logic ext;
    logic unnorm;
    logic neg;
    logic zero;
    logic ovf;
  } flags_t;

  // Bit index receiving the rounding constant; low_w is the low word width.
  function automatic int round_pos(scale_e m, int low_w);
    case (m)
      SCL_DOWN: return low_w;
      SCL_UP:   return low_w - 2;
      default:  return low_w - 1;
    endcase
  endfunction

endpackage

// File: rtl/fmac_product_stage.sv
module fmac_product_stage
  import fmac_pkg::*;
#(
  parameter int OP_W  = 24,
  parameter int ACC_W = 56
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [OP_W-1:0]         op_x,
  input  logic [OP_W-1:0]         op_y,
  input  logic                    negate,
  input  logic [ACC_W-1:0]        acc_in,
  input  scale_e                  mode_in,
  input  logic                    lim_in,
  output logic                    s_valid,
  output logic signed [ACC_W-1:0] s_term,
  output logic [ACC_W-1:0]        s_acc,
  output scale_e                  s_mode,
  output logic                    s_lim
);
  localparam int PROD_W = 2 * OP_W;
  localparam int PAD_W  = ACC_W - PROD_W - 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  frac;
  logic signed [ACC_W-1:0]  term;

  always_comb begin
    prod = $signed(op_x) * $signed(op_y);
    frac = {{PAD_W{prod[PROD_W-1]}}, prod, 1'b0};
    term = negate ? -frac : frac;
  end

  always_ff @(posedge clk) begin
    if (rst) s_valid <= 1'b0;
    else     s_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s_term <= term;
      s_acc  <= acc_in;
      s_mode <= mode_in;
      s_lim  <= lim_in;
    end
  end

  AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s_valid); // R2

endmodule

// File: rtl/fmac_rounder.sv
module fmac_rounder
  import fmac_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int LOW_W = 24
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] term,
  input  scale_e           mode,
  output logic [ACC_W-1:0] result,
  output logic             ovf
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  logic [SUM_W-1:0] sum_w, half, below, added, cleared;
  logic [SUM_W-ACC_W:0] top_bits;
  logic             tie;
  int               rp, keep;

  always_comb begin
    rp      = round_pos(mode, LOW_W);
    keep    = (rp + 1 > LOW_W) ? rp + 1 : LOW_W;
    sum_w   = {{2{acc[ACC_W-1]}}, acc} + {{2{term[ACC_W-1]}}, term};
    half    = ONE << rp;
    below   = (half << 1) - ONE;
    tie     = (sum_w & below) == half;
    added   = sum_w + half;
    if (tie) added = added & ~(half << 1);
    cleared = added & ~((ONE << keep) - ONE);
    top_bits = cleared[SUM_W-1:ACC_W-1];
    ovf     = !((&top_bits) || !(|top_bits));
    result  = cleared[ACC_W-1:0];
  end

endmodule

// File: rtl/fmac_flagger.sv
module fmac_flagger
  import fmac_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int EXT_W = 8
) (
  input  logic [ACC_W-1:0] res,
  input  scale_e           mode,
  input  logic             ovf,
  input  logic             lim_in,
  output flags_t           fl
);
  localparam int NRM = ACC_W - EXT_W - 1;

  logic [2:0] ext_c, un_c;

  for (genvar g = 0; g < 3; g++) begin : g_win
    localparam int LOB = (g == 1) ? NRM + 1 : (g == 2) ? NRM - 1 : NRM;
    logic [ACC_W-1-LOB:0] win;
    assign win      = res[ACC_W-1:LOB];
    assign ext_c[g] = !((&win) || !(|win));
    assign un_c[g]  = !(res[LOB] ^ res[LOB-1]);
  end

  logic [1:0] idx;

  always_comb begin
    case (mode)
      SCL_DOWN: idx = 2'd1;
      SCL_UP:   idx = 2'd2;
      default:  idx = 2'd0;
    endcase
    fl.ovf    = ovf;
    fl.lim    = lim_in | ovf;
    fl.neg    = res[ACC_W-1];
    fl.zero   = (res == '0);
    fl.ext    = ext_c[idx];
    fl.unnorm = un_c[idx];
  end

endmodule

// File: rtl/fmac_round_unit.sv
module fmac_round_unit
  import fmac_pkg::*;
#(
  parameter int OP_W  = 24,
  parameter int EXT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [OP_W-1:0]            op_x,
  input  logic [OP_W-1:0]            op_y,
  input  logic                       negate,
  input  logic [EXT_W+2*OP_W-1:0]    acc_in,
  input  logic [1:0]                 scale_mode,
  input  logic                       limit_in,
  output logic [EXT_W+2*OP_W-1:0]    acc_out,
  output logic                       done,
  output logic                       flg_limit,
  output logic                       flg_ext,
  output logic                       flg_unnorm,
  output logic                       flg_neg,
  output logic                       flg_zero,
  output logic                       flg_ovf
);
  localparam int ACC_W = EXT_W + 2 * OP_W;
  localparam int LOW_W = OP_W;

  logic                    s_valid, s_lim, r_ovf;
  logic signed [ACC_W-1:0] s_term;
  logic [ACC_W-1:0]        s_acc, r_res;
  scale_e                  s_mode;
  flags_t                  r_fl, q_fl;

  fmac_product_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
    .clk(clk), .rst(rst), .in_valid(start),
    .op_x(op_x), .op_y(op_y), .negate(negate), .acc_in(acc_in),
    .mode_in(scale_e'(scale_mode)), .lim_in(limit_in),
    .s_valid(s_valid), .s_term(s_term), .s_acc(s_acc),
    .s_mode(s_mode), .s_lim(s_lim)
  );

  fmac_rounder #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_rnd (
    .acc(s_acc), .term(s_term), .mode(s_mode),
    .result(r_res), .ovf(r_ovf)
  );

  fmac_flagger #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_flg (
    .res(r_res), .mode(s_mode), .ovf(r_ovf), .lim_in(s_lim), .fl(r_fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      acc_out <= '0;
      q_fl    <= '0;
    end else begin
      done <= s_valid;
      if (s_valid) begin
        acc_out <= r_res;
        q_fl    <= r_fl;
      end
    end
  end

  assign flg_limit  = q_fl.lim;
  assign flg_ext    = q_fl.ext;
  assign flg_unnorm = q_fl.unnorm;
  assign flg_neg    = q_fl.neg;
  assign flg_zero   = q_fl.zero;
  assign flg_ovf    = q_fl.ovf;

  AST_DONE_AFTER_TWO: assert property (@(posedge clk) disable iff (rst)
    start |=> ##1 done); // R2
  AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2)); // R2
  AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> acc_out[LOW_W-1:0] == '0); // R6
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |-> flg_neg == acc_out[ACC_W-1]); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |-> flg_zero == (acc_out == '0)); // R7
  AST_LIMIT_COVERS_OVF: assert property (@(posedge clk) disable iff (rst)
    (done && flg_ovf) |-> flg_limit); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(acc_out) && $stable(q_fl))); // R12

endmodule

// File: tb/fmac_round_unit_tb.sv
module fmac_round_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, negate = 1'b0, limit_in = 1'b0;
  logic [23:0] op_x = '0, op_y = '0;
  logic [55:0] acc_in = '0;
  logic [1:0]  scale_mode = '0;
  logic [55:0] acc_out;
  logic        done, flg_limit, flg_ext, flg_unnorm, flg_neg, flg_zero, flg_ovf;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmac_round_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .op_x(op_x), .op_y(op_y),
    .negate(negate), .acc_in(acc_in), .scale_mode(scale_mode),
    .limit_in(limit_in), .acc_out(acc_out), .done(done),
    .flg_limit(flg_limit), .flg_ext(flg_ext), .flg_unnorm(flg_unnorm),
    .flg_neg(flg_neg), .flg_zero(flg_zero), .flg_ovf(flg_ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: flags packed as {l,e,u,n,z,v}
  function automatic void ref_op(input logic [23:0] x, input logic [23:0] y,
                                 input logic ng, input logic [55:0] acc,
                                 input logic [1:0] md, input logic li,
                                 output logic [55:0] r, output logic [5:0] f);
    longint a, p, s, half, t, rs, lo_lim, hi_lim;
    int rp, keep, k;
    logic tie, v, e, u;
    a = $signed(acc);
    p = longint'($signed(x)) * longint'($signed(y)) * 2;
    if (ng) p = -p;
    s = a + p;
    rp = (md == 2'b01) ? 24 : (md == 2'b10) ? 22 : 23;
    half = longint'(1) << rp;
    tie = (s & ((half << 1) - 1)) == half;
    t = s + half;
    if (tie) t = t & ~(half << 1);
    keep = (rp + 1 > 24) ? rp + 1 : 24;
    t = t & ~((longint'(1) << keep) - 1);
    hi_lim = (longint'(1) << 55) - 1;
    lo_lim = -(longint'(1) << 55);
    v = (t > hi_lim) || (t < lo_lim);
    r = t[55:0];
    rs = {{8{r[55]}}, r};
    k = (md == 2'b01) ? 48 : (md == 2'b10) ? 46 : 47;
    e = !(((rs >>> k) == 0) || ((rs >>> k) == -1));
    u = (r[k] == r[k-1]);
    f = {li | v, e, u, r[55], r == 56'd0, v};
  endfunction

  // Cycle model of the two register stages
  logic        m1_v = 0, m1_ng = 0, m1_li = 0, m_done = 0, m_rst = 1;
  logic [23:0] m1_x = 0, m1_y = 0;
  logic [55:0] m1_acc = 0, m_acc = 0;
  logic [1:0]  m1_md = 0;
  logic [5:0]  m_fl = 0;

  always @(posedge clk) begin
    logic [55:0] r;
    logic [5:0]  f;
    cyc++;
    m_rst = rst;
    if (rst) begin
      m1_v = 0; m_done = 0; m_acc = 0; m_fl = 0;
    end else begin
      if (m1_v) begin
        ref_op(m1_x, m1_y, m1_ng, m1_acc, m1_md, m1_li, r, f);
        m_acc = r; m_fl = f;
      end
      m_done = m1_v;
      m1_v = start; m1_x = op_x; m1_y = op_y; m1_ng = negate;
      m1_acc = acc_in; m1_md = scale_mode; m1_li = limit_in;
    end
    if (cyc >= WD_LIMIT) begin
      n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      if (m_rst) begin
        chk("R1 reset", {7'd0, done, acc_out}, 64'd0);
        chk("R1 reset flags", {58'd0, flg_limit, flg_ext, flg_unnorm, flg_neg, flg_zero, flg_ovf}, 64'd0);
      end else begin
        chk("R2 done", {63'd0, done}, {63'd0, m_done});
        chk(m_done ? "R3 upper" : "R12 hold", {32'd0, acc_out[55:24]}, {32'd0, m_acc[55:24]});
        chk("R6 low word", {40'd0, acc_out[23:0]}, {40'd0, m_acc[23:0]});
        chk("R7 n/z", {62'd0, flg_neg, flg_zero}, {62'd0, m_fl[2], m_fl[1]});
        chk("R8 ovf", {63'd0, flg_ovf}, {63'd0, m_fl[0]});
        chk("R9 limit", {63'd0, flg_limit}, {63'd0, m_fl[5]});
        chk("R10 ext", {63'd0, flg_ext}, {63'd0, m_fl[4]});
        chk("R11 unnorm", {63'd0, flg_unnorm}, {63'd0, m_fl[3]});
      end
    end
  end

  task automatic run_op(input logic [23:0] x, input logic [23:0] y, input logic ng,
                        input logic [55:0] acc, input logic [1:0] md, input logic li);
    @(negedge clk);
    start = 1; op_x = x; op_y = y; negate = ng; acc_in = acc; scale_mode = md; limit_in = li;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk("R2 done after two edges", {63'd0, done}, 64'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R3 worked example, add and subtract
    run_op(24'h123456, 24'h123456, 0, 56'h00_100000_000000, 2'b00, 0);
    chk("R3 example", {8'd0, acc_out}, 64'h00_1296CE_000000);
    run_op(24'h123456, 24'h123456, 1, 56'h00_1296CD_9619C8 + 56'h00_000000_000000, 2'b00, 0);
    chk("R3 negate", {8'd0, acc_out}, {8'd0, 56'h00_100000_000000 + 56'h00_000000_000000});
    // R4 rounding position per mode
    run_op(24'h0, 24'h0, 0, 56'h00_000000_B00000, 2'b00, 0);
    chk("R4 mode00", {8'd0, acc_out}, 64'h00_000001_000000);
    run_op(24'h0, 24'h0, 0, 56'h00_000000_B00000, 2'b10, 0);
    chk("R4 mode10", {8'd0, acc_out}, 64'h0);
    run_op(24'h0, 24'h0, 0, 56'h00_000000_B00000, 2'b11, 0);
    chk("R4 mode11", {8'd0, acc_out}, 64'h00_000001_000000);
    run_op(24'h0, 24'h0, 0, 56'h00_000001_800000, 2'b01, 0);
    chk("R4 mode01", {8'd0, acc_out}, 64'h00_000002_000000);
    // R5 ties to even
    run_op(24'h0, 24'h0, 0, 56'h00_000002_800000, 2'b00, 0);
    chk("R5 tie even stays", {8'd0, acc_out}, 64'h00_000002_000000);
    run_op(24'h0, 24'h0, 0, 56'h00_000003_800000, 2'b00, 0);
    chk("R5 tie odd up", {8'd0, acc_out}, 64'h00_000004_000000);
    run_op(24'h0, 24'h0, 0, 56'h00_000001_000000, 2'b01, 0);
    chk("R5 tie mode01", {8'd0, acc_out}, 64'h0);
    run_op(24'h0, 24'h0, 0, 56'h00_000003_000000, 2'b01, 0);
    chk("R5 tie mode01 odd", {8'd0, acc_out}, 64'h00_000004_000000);
    // R8 overflow from rounding alone, R9 limit
    run_op(24'h0, 24'h0, 0, 56'h7F_FFFFFF_900000, 2'b00, 0);
    chk("R8 wrap", {8'd0, acc_out}, 64'h80_000000_000000);
    chk("R8 ovf set", {63'd0, flg_ovf}, 64'd1);
    chk("R9 limit from ovf", {63'd0, flg_limit}, 64'd1);
    run_op(24'h400000, 24'h400000, 0, 56'h00_000000_000000, 2'b00, 1);
    chk("R9 limit sticky in", {62'd0, flg_limit, flg_ovf}, 64'd2);
    // R10/R11 windows
    run_op(24'h0, 24'h0, 0, 56'h00_400000_000000, 2'b00, 0);
    chk("R10 R11 mode00", {62'd0, flg_ext, flg_unnorm}, 64'd0);
    run_op(24'h0, 24'h0, 0, 56'h00_400000_000000, 2'b01, 0);
    chk("R10 R11 mode01", {62'd0, flg_ext, flg_unnorm}, 64'd1);
    run_op(24'h0, 24'h0, 0, 56'h00_400000_000000, 2'b10, 0);
    chk("R10 R11 mode10", {62'd0, flg_ext, flg_unnorm}, 64'd2);
    // Random traffic, back-to-back and gaps, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = ($urandom % 4) != 0;
      op_x = $urandom; op_y = $urandom;
      if ($urandom % 8 == 0) op_x = 24'h800000;
      negate = $urandom; scale_mode = $urandom; limit_in = ($urandom % 4) == 0;
      acc_in = {$urandom, $urandom};
      case ($urandom % 4)
        0: acc_in[55:47] = {9{acc_in[46]}};
        1: acc_in[24:0] = 25'h0800000;
        2: acc_in[24:0] = 25'h1000000;
        default: ;
      endcase
    end
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule